// File: doc/BRIEF.md
# Serial ADC Register Loader

This block sets up the configuration registers of a CCD analog front-end converter over a three-wire serial link made of a serial clock, a serial data line and an active-low load strobe. Right after reset it sends a fixed sequence of default register writes. The defaults select one channel in correlated double sampling mode with a 3 V input span and the green channel, and they set unity gain and zero offset on all three colour channels, including the two that are not used.

After the defaults, every falling edge of the active-low acquire strobe captures the address and data switch inputs. The captured pair is then sent as one register write. This happens the same way whether the camera is in still or free-run mode, because the mode has no effect here. A request that arrives while writes are still going out is held back and sent once they finish. An external-control select hands the three serial lines over to off-board pins.

Top module: `adc_cfg_loader`

## Requirements
- R1: Each write frame holds 12 bits, sent MSB first: a 3-bit register address followed by a 9-bit data word. The load line is low for exactly 48 system clocks during a frame. After a frame the load line stays high for at least 4 clocks.
- R2: The serial clock is the system clock divided by 4. It is low for 2 clocks and high for 2, so successive rising edges within a frame are 4 clocks apart. It stays low whenever the load line is high.
- R3: Serial data changes only while the serial clock is low. It holds its value for as long as the clock is high.
- R4: After reset, eight writes go out in ascending address order 0 to 7. Address 0 gets 0x0D8 (one channel, CDS, 3 V span). Address 1 gets 0x040 (green selected). Addresses 2 to 4 are the red, green and blue gains and get 0, which means unity gain. Addresses 5 to 7 are the red, green and blue offsets and get 0, which means 0 mV.
- R5: An acquire strobe sampled high at one clock edge and low at the next captures sw_addr and sw_data at that second edge. Exactly one frame then carries that pair. Changing the switches after the capture has no effect on it.
- R6: A strobe that arrives while writes are in progress, including the default sequence, is queued and sent after them. The queue holds one entry, so a newer strobe replaces an unsent one.
- R7: Busy is high during reset and from the clock edge that accepts a strobe until the gap after the last frame ends. The load line falls one clock after a strobe is accepted while idle.
- R8: While ext_sel is high, the three serial outputs follow ext_sclk, ext_sdata and ext_load_n in the same cycle.
- R9: During reset, load is high, the serial clock is low and serial data is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_n | input | 1 | Active-low acquire strobe; a falling edge requests a write |
| sw_addr | input | 3 | Register address switches |
| sw_data | input | 9 | Register data switches |
| ext_sel | input | 1 | Hands the serial lines to the external pins |
| ext_sclk | input | 1 | External serial clock |
| ext_sdata | input | 1 | External serial data |
| ext_load_n | input | 1 | External load strobe |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_o | output | 1 | Serial data to the converter |
| load_n_o | output | 1 | Active-low load strobe to the converter |
| busy_o | output | 1 | Writes are pending or in progress |

## Verification
A wrong phase or bit count shows up within one frame, as a load pulse that is not 48 clocks wide or as a clock rise spacing that is not 4. A wrong shift order or a wrong default index gives a wrong captured address or data word at the next rising edge of the load line. A lost or duplicated queued request changes the number of captured frames once busy falls. A wrong busy term is visible one clock after a strobe.

// File: rtl/adc_cfg_loader.sv
module adc_cfg_loader #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 9,
  parameter int DIV = 4,
  parameter int NUM_DEF = 8,
  parameter logic [8:0] DEF_CFG = 9'h0D8,
  parameter logic [8:0] DEF_MUX = 9'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_n,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              ext_sel,
  input  logic              ext_sclk,
  input  logic              ext_sdata,
  input  logic              ext_load_n,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              load_n_o,
  output logic              busy_o
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int PH_W = $clog2(DIV);
  localparam int BC_W = $clog2(FRAME_W);
  localparam int IDX_W = $clog2(NUM_DEF + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_t;

  state_t             state;
  logic [PH_W-1:0]    ph;
  logic [BC_W-1:0]    bitcnt;
  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;
  logic               acq_q;
  logic               pend;
  logic [FRAME_W-1:0] pend_word;

  function automatic logic [FRAME_W-1:0] def_word(input logic [IDX_W-1:0] i);
    logic [DATA_W-1:0] d;
    if (i == IDX_W'(0))      d = DATA_W'(DEF_CFG);
    else if (i == IDX_W'(1)) d = DATA_W'(DEF_MUX);
    else                     d = '0;
    return {ADDR_W'(i), d};
  endfunction

  wire acq_fall = acq_q & ~acq_n;
  wire def_done = (idx == IDX_W'(NUM_DEF));
  wire ph_last  = (ph == PH_W'(DIV - 1));
  wire in_frame = (state == S_SHIFT);
  wire sclk_i   = in_frame & (ph >= PH_W'(DIV / 2));
  wire sdata_i  = in_frame & shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ph        <= '0;
      bitcnt    <= '0;
      shreg     <= '0;
      idx       <= '0;
      acq_q     <= 1'b1;
      pend      <= 1'b0;
      pend_word <= '0;
    end else begin
      acq_q <= acq_n;
      case (state)
        S_IDLE: begin
          ph     <= '0;
          bitcnt <= '0;
          if (!def_done) begin
            shreg <= def_word(idx);
            idx   <= idx + 1'b1;
            state <= S_SHIFT;
          end else if (pend && !acq_fall) begin
            shreg <= pend_word;
            pend  <= 1'b0;
            state <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          ph <= ph_last ? '0 : ph + 1'b1;
          if (ph_last) begin
            if (bitcnt == BC_W'(FRAME_W - 1)) begin
              state <= S_GAP;
            end else begin
              shreg  <= shreg << 1;
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: begin
          ph <= ph_last ? '0 : ph + 1'b1;
          if (ph_last) state <= S_IDLE;
        end
      endcase
      if (acq_fall) begin
        pend      <= 1'b1;
        pend_word <= {sw_addr, sw_data};
      end
    end
  end

  assign sclk_o   = ext_sel ? ext_sclk : sclk_i;
  assign sdata_o  = ext_sel ? ext_sdata : sdata_i;
  assign load_n_o = ext_sel ? ext_load_n : ~in_frame;
  assign busy_o   = (state != S_IDLE) | ~def_done | pend;

  AST_FRAME_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frame) |-> bitcnt == BC_W'(FRAME_W - 1)); // R1
  AST_GAP_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_IDLE) |-> $past(state) == S_GAP); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_i && $past(sclk_i)) |-> $stable(sdata_i)); // R3
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && state != S_IDLE) |=> pend); // R6
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(NUM_DEF)); // R4
endmodule

// File: tb/adc_cfg_loader_tb.sv
module adc_cfg_loader_tb;
  localparam int DIV = 4;
  localparam int FRAME_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_n = 1'b1;
  logic [2:0] sw_addr = '0;
  logic [8:0] sw_data = '0;
  logic ext_sel = 1'b0, ext_sclk = 1'b0, ext_sdata = 1'b0, ext_load_n = 1'b1;
  logic sclk_o, sdata_o, load_n_o, busy_o;

  int n_chk = 0, n_bad = 0;
  logic [11:0] log_w [0:255];
  int log_n = 0;

  always #10 clk = ~clk;

  adc_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .acq_n(acq_n), .sw_addr(sw_addr), .sw_data(sw_data),
    .ext_sel(ext_sel), .ext_sclk(ext_sclk), .ext_sdata(ext_sdata), .ext_load_n(ext_load_n),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .load_n_o(load_n_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_def(input int i);
    logic [8:0] d;
    d = (i == 0) ? 9'h0D8 : (i == 1) ? 9'h040 : 9'h000;
    return {i[2:0], d};
  endfunction

  // converter-side capture model, sampled at falling system clock edges
  logic p_load = 1'b1, p_sclk = 1'b0, p_sd = 1'b0;
  int cyc = 0, t_fall = 0, t_rise = 0, nb = 0;
  logic [11:0] sh = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !ext_sel) begin
      if (p_load && !load_n_o) begin nb = 0; t_fall = cyc; end
      if (!load_n_o && sclk_o && !p_sclk) begin
        if (nb > 0) chk(cyc - t_rise == DIV, "R2 sclk rise spacing", cyc - t_rise, DIV);
        t_rise = cyc;
        sh = {sh[10:0], sdata_o};
        nb++;
      end
      if (!load_n_o && sclk_o && p_sclk)
        chk(sdata_o == p_sd, "R3 data moved while sclk high", sdata_o, p_sd);
      if (!p_load && load_n_o) begin
        chk(cyc - t_fall == FRAME_W * DIV, "R1 load low width", cyc - t_fall, FRAME_W * DIV);
        chk(nb == FRAME_W, "R1 bits per frame", nb, FRAME_W);
        if (log_n < 256) log_w[log_n] = sh;
        log_n++;
      end
      if (load_n_o) chk(!sclk_o, "R2 sclk low outside frame", sclk_o, 0);
    end
    p_load = load_n_o;
    p_sclk = sclk_o;
    p_sd = sdata_o;
  end

  task automatic strobe(input logic [2:0] a, input logic [8:0] d);
    @(negedge clk);
    sw_addr = a; sw_data = d; acq_n = 1'b0;
    @(negedge clk);
    acq_n = 1'b1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic [2:0] ra;
    logic [8:0] rd;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(load_n_o == 1'b1, "R9 load high in reset", load_n_o, 1);
    chk(sclk_o == 1'b0, "R9 sclk low in reset", sclk_o, 0);
    chk(sdata_o == 1'b0, "R9 sdata low in reset", sdata_o, 0);
    chk(busy_o == 1'b1, "R7 busy in reset", busy_o, 1);
    @(negedge clk); rst_n = 1'b1;

    // R6: request during the default sequence waits until the defaults finish
    repeat (100) @(negedge clk);
    strobe(3'd5, 9'h1A5);
    wait_idle();
    chk(log_n == 9, "R6 frames after defaults plus queued", log_n, 9);
    for (int i = 0; i < 8; i++)
      chk(log_w[i] == exp_def(i), "R4 default write", log_w[i], exp_def(i));
    chk(log_w[8] == {3'd5, 9'h1A5}, "R6 queued write after defaults", log_w[8], {3'd5, 9'h1A5});

    // R7: busy one edge after acceptance, load falls one edge later
    @(negedge clk);
    sw_addr = 3'd3; sw_data = 9'h0FF; acq_n = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b1, "R7 busy after strobe", busy_o, 1);
    chk(load_n_o == 1'b1, "R7 load still high", load_n_o, 1);
    acq_n = 1'b1;
    sw_addr = 3'd6; sw_data = 9'h111;  // R5: later switch change is ignored
    @(negedge clk);
    chk(load_n_o == 1'b0, "R7 load falls next cycle", load_n_o, 0);
    wait_idle();
    chk(busy_o == 1'b0, "R7 busy low when done", busy_o, 0);
    chk(log_w[log_n-1] == {3'd3, 9'h0FF}, "R5 latched pair", log_w[log_n-1], {3'd3, 9'h0FF});

    // R6: two requests during one frame, the newer replaces the older
    base = log_n;
    strobe(3'd1, 9'h0AA);
    repeat (10) @(negedge clk);
    strobe(3'd2, 9'h155);
    repeat (3) @(negedge clk);
    strobe(3'd7, 9'h03C);
    wait_idle();
    chk(log_n == base + 2, "R6 frame count with overwrite", log_n, base + 2);
    chk(log_w[base] == {3'd1, 9'h0AA}, "R6 first write", log_w[base], {3'd1, 9'h0AA});
    chk(log_w[base+1] == {3'd7, 9'h03C}, "R6 newest queued write", log_w[base+1], {3'd7, 9'h03C});

    // R5: random switch pairs, one strobe each
    for (int k = 0; k < 24; k++) begin
      ra = 3'($urandom);
      rd = 9'($urandom);
      base = log_n;
      strobe(ra, rd);
      wait_idle();
      chk(log_n == base + 1, "R5 one frame per strobe", log_n, base + 1);
      chk(log_w[base] == {ra, rd}, "R5 random write", log_w[base], {ra, rd});
    end

    // R8: external control passes through
    @(negedge clk); ext_sel = 1'b1;
    for (int k = 0; k < 10; k++) begin
      ext_sclk = 1'($urandom); ext_sdata = 1'($urandom); ext_load_n = 1'($urandom);
      #1;
      chk(sclk_o == ext_sclk, "R8 sclk follows", sclk_o, ext_sclk);
      chk(sdata_o == ext_sdata, "R8 sdata follows", sdata_o, ext_sdata);
      chk(load_n_o == ext_load_n, "R8 load follows", load_n_o, ext_load_n);
      @(negedge clk);
    end
    ext_load_n = 1'b1; ext_sclk = 1'b0; ext_sdata = 1'b0;
    @(negedge clk); ext_sel = 1'b0;
    @(negedge clk);
    chk(load_n_o == 1'b1 && sclk_o == 1'b0, "R8 internal lines back idle", {load_n_o, sclk_o}, 2'b10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule